// File: doc/BRIEF.md
# Serial EEPROM Sequential Byte Fetcher

This block is an SPI master that pulls a boot image out of a serial EEPROM with 16-bit byte addressing, one byte per transfer. Every byte costs one self-contained 32-clock frame. The frame carries the read opcode, the full byte address and eight filler clocks, during which the memory returns its data. A pulse on `start_i` restarts the fetch at address zero. The address then advances by one per frame until the top of the space is reached.

Each fetched byte is offered to a downstream consumer on a valid/ready pair. The next frame is not launched until the current byte has been taken, so a slow consumer stretches the gaps between frames. The first two bytes must form the image marker 08h, AAh. If either is wrong, fetching stops and a no-image flag is raised.

When the consumer reports that it has finished with the image, a sticky active-low output falls. This output can park the memory through its hold input. An abort input stops the transfer within one cycle.

Top module: `eeprom_boot_reader`

## Requirements
- R1: A frame keeps `cs_no` low for exactly 32 rising edges of `sck_o`. MOSI carries, MSB first, the opcode 03h, then the 16-bit byte address (bit 15 first), then 8 zero bits. `sck_o` is low whenever `cs_no` is high. MOSI never changes at a rising edge of `sck_o`.
- R2: The delivered byte is the value of `miso_i` sampled at the last 8 rising edges of the frame, D7 first.
- R3: Inside a frame, consecutive rising edges of `sck_o` are exactly `CLK_DIV` system clocks apart (default 250).
- R4: After `start_i`, the first frame addresses byte 0, and each following frame addresses the previous address plus one.
- R5: `byte_o` holds steady while `byte_valid_o` is high and `byte_ready_i` is low. No frame starts (`cs_no` stays high) while a byte is waiting.
- R6: If byte 0 is not 08h or byte 1 is not AAh, that byte is not delivered, `no_image_o` rises, `busy_o` falls and no further frame starts. `start_i` clears `no_image_o` and `span_end_o`.
- R7: When the byte at address 2^ADDR_W-1 is accepted, `span_end_o` rises, `busy_o` falls and no further frame starts.
- R8: Between two frames `cs_no` stays high for at least `CLK_DIV` system clocks.
- R9: One cycle after `abort_i`, `cs_no` is high, `sck_o` is low, and `byte_valid_o` and `busy_o` are low. A byte handshaken in the same cycle as `abort_i` counts as delivered, and no further frame starts.
- R10: One cycle after `boot_done_i`, `hold_no` is low and fetching has stopped. `hold_no` stays low until reset, and `start_i` has no effect while it is low.
- R11: During and after reset, `cs_no` and `hold_no` are high, and `sck_o`, `byte_valid_o`, `busy_o`, `no_image_o` and `span_end_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin fetching at address 0 |
| abort_i | input | 1 | Stop at once, release the bus |
| boot_done_i | input | 1 | Consumer finished; drops hold_no |
| sck_o | output | 1 | Serial clock, idles low |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data to the memory |
| miso_i | input | 1 | Serial data from the memory |
| byte_o | output | 8 | Fetched byte |
| byte_valid_o | output | 1 | byte_o is valid |
| byte_ready_i | input | 1 | Consumer accepts byte_o |
| busy_o | output | 1 | Fetch sequence in progress |
| no_image_o | output | 1 | Image marker missing |
| span_end_o | output | 1 | Top of address space reached |
| hold_no | output | 1 | Memory hold control, low after completion |

## Verification
Two events can land in the same cycle: the consumer accepting the pending byte, and an abort. Accepting a byte normally launches the next frame, while the abort must suppress it.

The bench holds ready low and releases it one cycle at a time, byte by byte. On the fourth byte it raises ready and `abort_i` together. Success means the scoreboard counts that byte as delivered, and that chip select then stays high and busy stays low for the following stretch of cycles.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  localparam logic [7:0] READ_OP   = 8'h03;
  localparam logic [7:0] MARK_HI   = 8'h08;
  localparam logic [7:0] MARK_LO   = 8'hAA;
  localparam int         FRAME_LEN = 32;
  localparam int         WIRE_AW   = 16;

  typedef enum logic [1:0] {
    E_IDLE,
    E_LOW,
    E_HIGH,
    E_GAP
  } eng_state_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_OFFER
  } seq_state_e;
endpackage

// File: rtl/ebr_sck_div.sv
module ebr_sck_div #(
  parameter int HALF = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ebr_frame_engine.sv
module ebr_frame_engine
  import ebr_pkg::*;
#(
  parameter int HALF = 125
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        go_i,
  input  logic        stop_i,
  input  logic [31:0] cmd_i,
  input  logic        miso_i,
  output logic        sck_o,
  output logic        cs_no,
  output logic        mosi_o,
  output logic        done_o,
  output logic [7:0]  rx_o
);
  localparam logic [4:0] LAST_BIT = 5'(FRAME_LEN - 1);

  eng_state_e  st_q;
  logic [31:0] tx_q;
  logic [4:0]  bit_q;
  logic [7:0]  rx_q;
  logic        gap_q, sck_q, cs_q, done_q;
  logic        tick;

  ebr_sck_div #(.HALF(HALF)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q != E_IDLE),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= E_IDLE;
      tx_q   <= '0;
      bit_q  <= '0;
      rx_q   <= '0;
      gap_q  <= 1'b0;
      sck_q  <= 1'b0;
      cs_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (stop_i) begin
        st_q  <= E_IDLE;
        sck_q <= 1'b0;
        cs_q  <= 1'b1;
      end else begin
        unique case (st_q)
          E_IDLE: if (go_i) begin
            tx_q  <= cmd_i;
            bit_q <= '0;
            cs_q  <= 1'b0;
            sck_q <= 1'b0;
            st_q  <= E_LOW;
          end
          // rising edge: memory and master both sample
          E_LOW: if (tick) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], miso_i};
            st_q  <= E_HIGH;
          end
          // falling edge: advance MOSI or close the frame
          E_HIGH: if (tick) begin
            sck_q <= 1'b0;
            if (bit_q == LAST_BIT) begin
              cs_q  <= 1'b1;
              gap_q <= 1'b0;
              st_q  <= E_GAP;
            end else begin
              tx_q  <= {tx_q[30:0], 1'b0};
              bit_q <= bit_q + 1'b1;
              st_q  <= E_LOW;
            end
          end
          // two half periods of deselect
          E_GAP: if (tick) begin
            if (gap_q) begin
              st_q   <= E_IDLE;
              done_q <= 1'b1;
            end else begin
              gap_q <= 1'b1;
            end
          end
          default: st_q <= E_IDLE;
        endcase
      end
    end
  end

  assign sck_o  = sck_q;
  assign cs_no  = cs_q;
  assign mosi_o = tx_q[31] & ~cs_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/ebr_sequencer.sv
module ebr_sequencer
  import ebr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        abort_i,
  input  logic        boot_done_i,
  input  logic        frame_done_i,
  input  logic [7:0]  rx_i,
  input  logic        byte_ready_i,
  output logic        go_o,
  output logic        stop_o,
  output logic [31:0] cmd_o,
  output logic [7:0]  byte_o,
  output logic        byte_valid_o,
  output logic        busy_o,
  output logic        no_image_o,
  output logic        span_end_o,
  output logic        hold_no
);
  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;
  localparam logic [ADDR_W-1:0] ADDR_0   = '0;
  localparam logic [ADDR_W-1:0] ADDR_1   = ADDR_W'(1);

  seq_state_e        st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              go_q, noimg_q, end_q, hold_q;
  logic              mark_bad, halt;

  assign halt     = abort_i | boot_done_i;
  assign mark_bad = ((addr_q == ADDR_0) && (rx_i != MARK_HI)) ||
                    ((addr_q == ADDR_1) && (rx_i != MARK_LO));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      go_q    <= 1'b0;
      noimg_q <= 1'b0;
      end_q   <= 1'b0;
      hold_q  <= 1'b1;
    end else begin
      go_q <= 1'b0;
      if (boot_done_i) hold_q <= 1'b0;
      if (halt) begin
        st_q <= S_IDLE;
      end else begin
        unique case (st_q)
          S_IDLE: if (start_i && hold_q) begin
            addr_q  <= '0;
            noimg_q <= 1'b0;
            end_q   <= 1'b0;
            go_q    <= 1'b1;
            st_q    <= S_FETCH;
          end
          S_FETCH: if (frame_done_i) begin
            if (mark_bad) begin
              noimg_q <= 1'b1;
              st_q    <= S_IDLE;
            end else begin
              data_q <= rx_i;
              st_q   <= S_OFFER;
            end
          end
          S_OFFER: if (byte_ready_i) begin
            if (addr_q == ADDR_TOP) begin
              end_q <= 1'b1;
              st_q  <= S_IDLE;
            end else begin
              addr_q <= addr_q + 1'b1;
              go_q   <= 1'b1;
              st_q   <= S_FETCH;
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign go_o         = go_q;
  assign stop_o       = halt;
  assign cmd_o        = {READ_OP, WIRE_AW'(addr_q), 8'h00};
  assign byte_o       = data_q;
  assign byte_valid_o = (st_q == S_OFFER);
  assign busy_o       = (st_q != S_IDLE);
  assign no_image_o   = noimg_q;
  assign span_end_o   = end_q;
  assign hold_no      = hold_q;
endmodule

// File: rtl/eeprom_boot_reader.sv
module eeprom_boot_reader #(
  parameter int CLK_DIV = 250,
  parameter int ADDR_W  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       abort_i,
  input  logic       boot_done_i,
  output logic       sck_o,
  output logic       cs_no,
  output logic       mosi_o,
  input  logic       miso_i,
  output logic [7:0] byte_o,
  output logic       byte_valid_o,
  input  logic       byte_ready_i,
  output logic       busy_o,
  output logic       no_image_o,
  output logic       span_end_o,
  output logic       hold_no
);
  localparam int HALF = CLK_DIV / 2;

  logic        go, stop, frame_done;
  logic [31:0] cmd;
  logic [7:0]  rx;

  ebr_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .abort_i      (abort_i),
    .boot_done_i  (boot_done_i),
    .frame_done_i (frame_done),
    .rx_i         (rx),
    .byte_ready_i (byte_ready_i),
    .go_o         (go),
    .stop_o       (stop),
    .cmd_o        (cmd),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o),
    .busy_o       (busy_o),
    .no_image_o   (no_image_o),
    .span_end_o   (span_end_o),
    .hold_no      (hold_no)
  );

  ebr_frame_engine #(.HALF(HALF)) u_eng (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .stop_i (stop),
    .cmd_i  (cmd),
    .miso_i (miso_i),
    .sck_o  (sck_o),
    .cs_no  (cs_no),
    .mosi_o (mosi_o),
    .done_o (frame_done),
    .rx_o   (rx)
  );
endmodule

// File: rtl/ebr_checker.sv
module ebr_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       abort_i,
  input logic       boot_done_i,
  input logic       sck_o,
  input logic       cs_no,
  input logic       mosi_o,
  input logic [7:0] byte_o,
  input logic       byte_valid_o,
  input logic       byte_ready_i,
  input logic       busy_o,
  input logic       no_image_o,
  input logic       span_end_o,
  input logic       hold_no
);
  // R1
  sck_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !cs_no);

  // R1
  mosi_steady_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && $rose(sck_o)) |-> $stable(mosi_o));

  // R5
  byte_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i && !abort_i && !boot_done_i)
      |=> (byte_valid_o && $stable(byte_o)));

  // R5
  no_frame_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> cs_no);

  // R6
  noimg_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_image_o |-> (!busy_o && !span_end_o));

  // R9
  abort_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (cs_no && !sck_o && !byte_valid_o && !busy_o));

  // R10
  done_drops_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_done_i |=> (!hold_no && !busy_o));

  // R10
  hold_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_no |=> !hold_no);
endmodule

bind eeprom_boot_reader ebr_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .abort_i      (abort_i),
  .boot_done_i  (boot_done_i),
  .sck_o        (sck_o),
  .cs_no        (cs_no),
  .mosi_o       (mosi_o),
  .byte_o       (byte_o),
  .byte_valid_o (byte_valid_o),
  .byte_ready_i (byte_ready_i),
  .busy_o       (busy_o),
  .no_image_o   (no_image_o),
  .span_end_o   (span_end_o),
  .hold_no      (hold_no)
);

// File: tb/tb_eeprom_boot_reader.sv
`timescale 1ns/1ps
module tb_eeprom_boot_reader;
  localparam int DIV = 4;
  localparam int AW  = 4;
  localparam int NB  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, abort = 1'b0, boot_done = 1'b0, miso = 1'b0;
  logic ready;
  logic sck, cs_n, mosi, valid, busy, no_img, span_end, hold_n;
  logic [7:0] byte_out;

  always #4 clk = ~clk;

  eeprom_boot_reader #(.CLK_DIV(DIV), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .boot_done_i(boot_done), .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi),
    .miso_i(miso), .byte_o(byte_out), .byte_valid_o(valid),
    .byte_ready_i(ready), .busy_o(busy), .no_image_o(no_img),
    .span_end_o(span_end), .hold_no(hold_n)
  );

  int checks = 0, errors = 0;
  int mode = 0;
  int rdy_mode = 0;
  logic rdy_force = 1'b0, pat = 1'b1;
  assign ready = (rdy_mode == 0) ? pat : rdy_force;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(int a);
    if (a == 0) return (mode == 1) ? 8'h3C : 8'h08;
    if (a == 1) return (mode == 2) ? 8'h55 : 8'hAA;
    return 8'((a * 29 + 7) ^ 8'h5A);
  endfunction

  // memory model
  int m_bits = 0, exp_addr = 0, frames = 0, glitch = 0;
  logic [31:0] m_sh = '0;
  logic [15:0] m_addr = '0;
  bit m_open = 0, frame_chk = 1;

  always @(negedge cs_n) begin m_open = 1; m_bits = 0; m_sh = '0; end
  always @(posedge sck) if (!cs_n) begin
    m_sh = {m_sh[30:0], mosi};
    m_bits++;
    if (m_bits == 24) m_addr = m_sh[15:0];
  end
  always @(negedge sck) if (!cs_n && m_bits >= 24 && m_bits < 32) begin
    logic [7:0] d;
    d = mem_byte(int'(m_addr));
    miso = d[31 - m_bits];
  end
  always @(posedge cs_n) if (m_open) begin
    m_open = 0;
    if (frame_chk) begin
      check(m_bits == 32, "R1", "clocks per frame", m_bits, 32);
      check(m_sh[31:24] == 8'h03, "R1", "opcode", m_sh[31:24], 8'h03);
      check(m_sh[7:0] == 8'h00, "R1", "filler", m_sh[7:0], 0);
      check(int'(m_addr) == exp_addr, "R4", "address", m_addr, exp_addr);
      check(glitch == 0, "R1", "mosi moved with sck high", glitch, 0);
    end
    exp_addr++;
    frames++;
  end

  initial forever begin
    int pc;
    @(posedge clk); #1;
    pc++;
    pat = ((pc % 5) != 0) && ((pc % 7) != 3);
  end

  // scoreboard monitor
  logic [7:0] exp_q[$];
  int cyc = 0, delivered = 0, gap_c = 0, last_rise = -1;
  logic sck_prev = 1'b0, mosi_prev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n && valid && ready) begin
      if (exp_q.size() == 0) check(0, "R5", "unexpected byte", byte_out, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(byte_out == e, "R2", "byte value", byte_out, e);
        check(cs_n == 1'b1, "R5", "cs while byte pending", cs_n, 1);
        delivered++;
      end
    end
    if (cs_n) gap_c++;
    else begin
      if (gap_c > 0 && frames > 0)
        check(gap_c >= DIV, "R8", "deselect gap", gap_c, DIV);
      gap_c = 0;
    end
    if (!cs_n && sck && !sck_prev) begin
      if (last_rise >= 0)
        check(cyc - last_rise == DIV, "R3", "sck period", cyc - last_rise, DIV);
      last_rise = cyc;
    end
    if (cs_n) last_rise = -1;
    if (!cs_n && sck && sck_prev && mosi !== mosi_prev) glitch++;
    sck_prev = sck;
    mosi_prev = mosi;
    if (cyc > 150000) begin
      check(0, "WDOG", "watchdog expired", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    do begin @(negedge clk); n++; end while (busy && n < 20000);
    check(!busy, req, "busy stuck", busy, 0);
  endtask

  task automatic count_cs_low(int n, string req);
    int lows = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (!cs_n || busy) lows++; end
    check(lows == 0, req, "activity after stop", lows, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 in reset
    check(cs_n == 1 && hold_n == 1, "R11", "cs/hold in reset", {cs_n, hold_n}, 3);
    check(!sck && !valid && !busy, "R11", "sck/valid/busy in reset", {sck, valid, busy}, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!no_img && !span_end && cs_n, "R11", "status after reset", {no_img, span_end, cs_n}, 1);

    // good image, ready with stalls
    mode = 0; exp_addr = 0; frames = 0;
    for (int a = 0; a < NB; a++) exp_q.push_back(mem_byte(a));
    pulse_start();
    wait_idle("R7");
    check(span_end == 1, "R7", "span end flag", span_end, 1);
    check(no_img == 0, "R6", "no image on good image", no_img, 0);
    check(exp_q.size() == 0, "R4", "bytes left over", exp_q.size(), 0);
    check(frames == NB, "R4", "frame count", frames, NB);
    count_cs_low(40, "R7");

    // bad first marker byte
    mode = 1; exp_addr = 0; frames = 0;
    pulse_start();
    check(span_end == 0, "R6", "start clears span end", span_end, 0);
    wait_idle("R6");
    check(no_img == 1, "R6", "no image, byte 0", no_img, 1);
    check(frames == 1, "R6", "frames, byte 0 bad", frames, 1);
    count_cs_low(30, "R6");

    // bad second marker byte
    mode = 2; exp_addr = 0; frames = 0;
    exp_q.push_back(8'h08);
    pulse_start();
    wait_idle("R6");
    check(no_img == 1, "R6", "no image, byte 1", no_img, 1);
    check(frames == 2, "R6", "frames, byte 1 bad", frames, 2);
    check(exp_q.size() == 0, "R6", "first byte delivered", exp_q.size(), 0);

    // abort mid-frame
    mode = 0; exp_addr = 0; frame_chk = 0;
    pulse_start();
    check(no_img == 0, "R6", "start clears no image", no_img, 0);
    repeat (30) @(posedge clk);
    #1 abort = 1'b1;
    @(posedge clk); #1 abort = 1'b0;
    @(negedge clk);
    check(cs_n && !sck && !busy && !valid, "R9", "state after abort",
          {cs_n, sck, busy, valid}, 8);
    frame_chk = 1;
    repeat (20) @(negedge clk);

    // abort together with acceptance
    rdy_mode = 1; rdy_force = 1'b0; exp_addr = 0;
    pulse_start();
    for (int k = 0; k < 4; k++) begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!valid && n < 2000);
      exp_q.push_back(mem_byte(k));
      @(posedge clk); #1 rdy_force = 1'b1;
      if (k == 3) abort = 1'b1;
      @(posedge clk); #1 rdy_force = 1'b0; abort = 1'b0;
    end
    @(negedge clk);
    check(!busy && !valid && cs_n, "R9", "stopped after abort+accept",
          {busy, valid, cs_n}, 1);
    check(exp_q.size() == 0, "R9", "concurrent byte delivered", exp_q.size(), 0);
    count_cs_low(60, "R9");
    rdy_mode = 0;

    // consumer completion
    mode = 0; exp_addr = 0;
    for (int a = 0; a < NB; a++) exp_q.push_back(mem_byte(a));
    begin
      int base = delivered, n = 0;
      pulse_start();
      do begin @(negedge clk); n++; end while (delivered < base + 2 && n < 5000);
    end
    frame_chk = 0;
    @(posedge clk); #1 boot_done = 1'b1;
    @(posedge clk); #1 boot_done = 1'b0;
    @(negedge clk);
    check(hold_n == 0, "R10", "hold after completion", hold_n, 0);
    check(!busy && cs_n, "R10", "fetch stopped", {busy, cs_n}, 1);
    exp_q.delete();
    frame_chk = 1;
    pulse_start();
    count_cs_low(40, "R10");
    check(hold_n == 0, "R10", "hold sticky", hold_n, 0);

    @(posedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    check(hold_n == 1, "R11", "hold restored by reset", hold_n, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule